// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block carries out the four partial-word memory operations of a 32-bit load/store pipeline: the left and right halves of an unaligned word load and of an unaligned word store. The caller supplies the effective address, the register number involved and that register's current contents. For loads it also supplies the register number and value of any load still waiting in the delayed-load slot. The unit reads the aligned word that holds the addressed byte. It then shifts and masks the register and memory bytes together according to the two low address bits.

A load delivers its merged value on a delayed-load result port, not to an immediate write-back path, so the register file can retire it with the same one-slot delay as any other load. A store writes its merged word back to the same aligned address after the read. Every operation ends with a one-cycle completion pulse.

The controller has four states. IDLE waits for a request, and "accept" leaves for READ. READ holds the read strobe; "read-ack" leads to WRITE for a store or to FINISH for a load. WRITE holds the write strobe, and "write-ack" leads to FINISH. FINISH raises the completion pulse and always returns to IDLE on the next edge.

Top module: `uamerge_top`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `busy`, `done`, `mem_rd`, `mem_wr` and `ld_valid` are all 0.
- R2: Every memory read and write is driven with `mem_addr` equal to the request address with bits [1:0] forced to zero.
- R3: Load-right (`req_op`=2'b00) with address offset k=addr[1:0] yields the memory word when k=0. For k=1, 2 and 3 it keeps the register's top k bytes and fills the rest with the memory word shifted right by 8k bits.
- R4: Load-left (`req_op`=2'b01) yields the memory word when k=3. For k=0, 1 and 2 it keeps the register's low 3-k bytes and places above them the memory word shifted left by 8(3-k) bits.
- R5: Store-right (`req_op`=2'b10) writes the register value when k=0. Otherwise it writes the memory's low k bytes, with the register shifted left by 8k bits above them.
- R6: Store-left (`req_op`=2'b11) writes the register value when k=3. Otherwise it writes the memory's top 3-k bytes, with the register shifted right by 8(3-k) bits below them.
- R7: For a load, when `pend_valid` is 1 and `pend_idx` equals `req_idx`, `pend_val` is merged in place of `req_val`. If the tag differs or `pend_valid` is 0, `req_val` is used.
- R8: A load ends with `ld_valid` high for exactly the `done` cycle, with `ld_idx` equal to the request's register number and `ld_data` holding the merged value. A store never raises `ld_valid`.
- R9: A store performs exactly one read and then exactly one write. The write strobe rises only after the read is acknowledged, and `mem_rd` and `mem_wr` are never high together. A load performs one read and no write.
- R10: `req_valid` is ignored while `busy` is 1. Such a request causes no extra memory access and does not change the operation in progress.
- R11: `mem_rd` or `mem_wr` stays high, with a stable address and write data, until `mem_ack` is seen.
- R12: `done` is a single-cycle pulse and `busy` is 0 on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 00 load-right, 01 load-left, 10 store-right, 11 store-left |
| req_addr | input | 32 | Effective byte address |
| req_idx | input | 5 | Register number (load destination / store source) |
| req_val | input | 32 | Register file value of that register |
| pend_valid | input | 1 | A delayed load is in flight |
| pend_idx | input | 5 | Destination register of the in-flight load |
| pend_val | input | 32 | Value of the in-flight load |
| mem_rd | output | 1 | Read strobe, held until acknowledge |
| mem_wr | output | 1 | Write strobe, held until acknowledge |
| mem_addr | output | 32 | Aligned word address |
| mem_wdata | output | 32 | Merged store word |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge for the current strobe |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| ld_valid | output | 1 | Delayed-load result valid |
| ld_idx | output | 5 | Delayed-load destination register |
| ld_data | output | 32 | Merged load value |

## Verification
The hardest case to reach from the ports is a second request arriving while a stretched store sits between its read and its write. The bench slows the memory responder to several cycles per access and holds a conflicting request on the inputs for the whole operation. It then checks that only one read and one write reached memory, both at the first request's address, and that the untouched word still holds its old value. Forwarding is reached by presenting a matching pending-load tag together with a register value that differs from the pending value. Two contrast cases follow: a mismatched tag, and a matching tag with the valid bit clear.

// File: rtl/uam_pkg.sv
`timescale 1ns/1ps
package uam_pkg;
    typedef enum logic [1:0] {
        OP_LD_RIGHT = 2'b00,
        OP_LD_LEFT  = 2'b01,
        OP_ST_RIGHT = 2'b10,
        OP_ST_LEFT  = 2'b11
    } uam_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_FINISH = 2'd3
    } uam_state_e;

    function automatic logic op_is_store(uam_op_e op);
        return op[1];
    endfunction
endpackage

// File: rtl/uam_opnd_sel.sv
`timescale 1ns/1ps
module uam_opnd_sel #(
    parameter int DATA_W = 32,
    parameter int RIDX_W = 5
) (
    input  logic              is_load,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [DATA_W-1:0] reg_val,
    input  logic              pend_valid,
    input  logic [RIDX_W-1:0] pend_idx,
    input  logic [DATA_W-1:0] pend_val,
    output logic [DATA_W-1:0] opnd
);
    logic hit;

    always_comb begin
        hit  = is_load && pend_valid && (pend_idx == reg_idx);
        opnd = hit ? pend_val : reg_val;
    end
endmodule

// File: rtl/uam_merge.sv
`timescale 1ns/1ps
module uam_merge
    import uam_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OFS_W  = $clog2(DATA_W / 8)
) (
    input  uam_op_e           op,
    input  logic [OFS_W-1:0]  ofs,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] result
);
    localparam int BYTES = DATA_W / 8;
    localparam int SH_W  = $clog2(DATA_W) + 2;

    logic [OFS_W-1:0]  ofs_inv;
    logic [SH_W-1:0]   sh_lo;
    logic [SH_W-1:0]   sh_hi;
    logic [SH_W-1:0]   sh_up;
    logic [DATA_W-1:0] ones;

    always_comb begin
        ones    = '1;
        ofs_inv = OFS_W'(BYTES - 1) - ofs;
        sh_lo   = SH_W'(ofs) << 3;
        sh_hi   = SH_W'(ofs_inv) << 3;
        sh_up   = sh_lo + SH_W'(8);
        unique case (op)
            OP_LD_RIGHT: result = (opnd & ~(ones >> sh_lo)) | (mem_word >> sh_lo);
            OP_LD_LEFT:  result = (opnd & (ones >> sh_up)) | (mem_word << sh_hi);
            OP_ST_RIGHT: result = (mem_word & ~(ones << sh_lo)) | (opnd << sh_lo);
            OP_ST_LEFT:  result = (mem_word & ~(ones >> sh_hi)) | (opnd >> sh_hi);
            default:     result = opnd;
        endcase
    end
endmodule

// File: rtl/uam_ctrl.sv
`timescale 1ns/1ps
module uam_ctrl
    import uam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic is_store,
    input  logic mem_ack,
    output logic accept,
    output logic rd_en,
    output logic wr_en,
    output logic rd_capture,
    output logic finish,
    output logic busy
);
    uam_state_e state_q;
    uam_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_READ;
            ST_READ:   if (mem_ack)   state_d = is_store ? ST_WRITE : ST_FINISH;
            ST_WRITE:  if (mem_ack)   state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept     = 1'b0;
        rd_en      = 1'b0;
        wr_en      = 1'b0;
        rd_capture = 1'b0;
        finish     = 1'b0;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = req_valid;
            end
            ST_READ: begin
                rd_en      = 1'b1;
                rd_capture = mem_ack;
            end
            ST_WRITE:  wr_en  = 1'b1;
            ST_FINISH: finish = 1'b1;
            default:   busy   = 1'b0;
        endcase
    end
endmodule

// File: rtl/uamerge_top.sv
`timescale 1ns/1ps
module uamerge_top
    import uam_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [RIDX_W-1:0] req_idx,
    input  logic [DATA_W-1:0] req_val,
    input  logic              pend_valid,
    input  logic [RIDX_W-1:0] pend_idx,
    input  logic [DATA_W-1:0] pend_val,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              busy,
    output logic              done,
    output logic              ld_valid,
    output logic [RIDX_W-1:0] ld_idx,
    output logic [DATA_W-1:0] ld_data
);
    localparam int BYTES = DATA_W / 8;
    localparam int OFS_W = $clog2(BYTES);

    uam_op_e           op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [RIDX_W-1:0] idx_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] result_q;

    logic              accept;
    logic              rd_capture;
    logic              finish;
    logic [DATA_W-1:0] opnd_sel;
    logic [DATA_W-1:0] merged;
    uam_op_e           req_op_e;

    assign req_op_e = uam_op_e'(req_op);

    uam_opnd_sel #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) fwd_i (
        .is_load    (!op_is_store(req_op_e)),
        .reg_idx    (req_idx),
        .reg_val    (req_val),
        .pend_valid (pend_valid),
        .pend_idx   (pend_idx),
        .pend_val   (pend_val),
        .opnd       (opnd_sel)
    );

    uam_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .is_store   (op_is_store(op_q)),
        .mem_ack    (mem_ack),
        .accept     (accept),
        .rd_en      (mem_rd),
        .wr_en      (mem_wr),
        .rd_capture (rd_capture),
        .finish     (finish),
        .busy       (busy)
    );

    uam_merge #(.DATA_W(DATA_W), .OFS_W(OFS_W)) merge_i (
        .op       (op_q),
        .ofs      (addr_q[OFS_W-1:0]),
        .opnd     (opnd_q),
        .mem_word (mem_rdata),
        .result   (merged)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q     <= OP_LD_RIGHT;
            addr_q   <= '0;
            idx_q    <= '0;
            opnd_q   <= '0;
            result_q <= '0;
        end else begin
            if (accept) begin
                op_q   <= req_op_e;
                addr_q <= req_addr;
                idx_q  <= req_idx;
                opnd_q <= opnd_sel;
            end
            if (rd_capture) result_q <= merged;
        end
    end

    assign mem_addr  = {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    assign mem_wdata = result_q;
    assign done      = finish;
    assign ld_valid  = finish && !op_is_store(op_q);
    assign ld_idx    = idx_q;
    assign ld_data   = result_q;
endmodule

// File: rtl/uam_checker.sv
`timescale 1ns/1ps
module uam_checker #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              busy,
    input logic              done,
    input logic              ld_valid
);
    assert_no_dual_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_word_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));

    assert_read_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

    assert_write_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    assert_ld_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> done);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_write_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr) |-> $past(mem_rd && mem_ack));
endmodule

bind uamerge_top uam_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .busy      (busy),
    .done      (done),
    .ld_valid  (ld_valid)
);

// File: tb/uamerge_top_tb_top.sv
`timescale 1ns/1ps
module uamerge_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic [31:0] req_addr = '0;
    logic [4:0]  req_idx = '0;
    logic [31:0] req_val = '0;
    logic        pend_valid = 1'b0;
    logic [4:0]  pend_idx = '0;
    logic [31:0] pend_val = '0;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        busy, done, ld_valid;
    logic [4:0]  ld_idx;
    logic [31:0] ld_data;

    int n_checks = 0;
    int n_fails  = 0;

    logic [31:0] mem [16];
    int          lat = 0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic        order_bad = 1'b0;
    logic [31:0] last_rd_addr = '0;
    logic [31:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;
    logic        got_ldv;
    logic [4:0]  got_idx;
    logic [31:0] got_data;

    always #2.5 clk = ~clk;

    uamerge_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_idx(req_idx), .req_val(req_val),
        .pend_valid(pend_valid), .pend_idx(pend_idx), .pend_val(pend_val),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .busy(busy), .done(done), .ld_valid(ld_valid), .ld_idx(ld_idx),
        .ld_data(ld_data)
    );

    // memory responder: answers after lat idle cycles
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (mem_rd || mem_wr) begin
                if (cnt < lat) cnt++;
                else begin
                    cnt = 0;
                    mem_ack = 1'b1;
                    if (mem_rd) begin
                        rd_cnt++;
                        last_rd_addr = mem_addr;
                        mem_rdata = mem[mem_addr[5:2]];
                    end
                    if (mem_wr) begin
                        if (rd_cnt == 0) order_bad = 1'b1;
                        wr_cnt++;
                        last_wr_addr = mem_addr;
                        last_wr_data = mem_wdata;
                        mem[mem_addr[5:2]] = mem_wdata;
                    end
                end
            end else cnt = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_merge(input logic [1:0] op, input logic [1:0] k,
                                              input logic [31:0] r, input logic [31:0] m);
        case ({op, k})
            4'b00_00: return m;
            4'b00_01: return (r & 32'hFF000000) | (m >> 8);
            4'b00_10: return (r & 32'hFFFF0000) | (m >> 16);
            4'b00_11: return (r & 32'hFFFFFF00) | (m >> 24);
            4'b01_00: return (r & 32'h00FFFFFF) | (m << 24);
            4'b01_01: return (r & 32'h0000FFFF) | (m << 16);
            4'b01_10: return (r & 32'h000000FF) | (m << 8);
            4'b01_11: return m;
            4'b10_00: return r;
            4'b10_01: return (m & 32'h000000FF) | (r << 8);
            4'b10_10: return (m & 32'h0000FFFF) | (r << 16);
            4'b10_11: return (m & 32'h00FFFFFF) | (r << 24);
            4'b11_00: return (m & 32'hFFFFFF00) | (r >> 24);
            4'b11_01: return (m & 32'hFFFF0000) | (r >> 16);
            4'b11_10: return (m & 32'hFF000000) | (r >> 8);
            default:  return r;
        endcase
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 16; i++) mem[i] = 32'h8A3C_5E71 ^ (32'h0101_0101 * i) ^ (i << 28);
    endtask

    // issue one request and wait for done; clears counters first
    task automatic run_op(input logic [1:0] op, input logic [31:0] addr, input logic [4:0] idx,
                          input logic [31:0] rv, input logic pv, input logic [4:0] pidx,
                          input logic [31:0] pval, input bit hold_other);
        @(negedge clk);
        rd_cnt = 0; wr_cnt = 0; order_bad = 1'b0;
        req_valid = 1'b1; req_op = op; req_addr = addr; req_idx = idx; req_val = rv;
        pend_valid = pv; pend_idx = pidx; pend_val = pval;
        @(negedge clk);
        if (hold_other) begin
            req_op = 2'b10; req_addr = 32'h0000_0034; req_idx = 5'd9; req_val = 32'h1357_9BDF;
        end else req_valid = 1'b0;
        got_ldv = 1'b0;
        for (int i = 0; i < 60; i++) begin
            if (done) break;
            @(negedge clk);
        end
        chk(done === 1'b1, "R12 done reached", {31'd0, done}, 32'd1);
        got_ldv = ld_valid; got_idx = ld_idx; got_data = ld_data;
        req_valid = 1'b0; pend_valid = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R12 done pulse ends", {30'd0, done, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk(busy === 0 && done === 0 && mem_rd === 0 && mem_wr === 0 && ld_valid === 0,
            "R1 reset state", {27'd0, busy, done, mem_rd, mem_wr, ld_valid}, 32'd0);
    endtask

    task automatic t_load(input logic [1:0] op, input string tag);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a, rv, m, e;
            a  = 32'h0000_0010 + 32'(k) + 32'(4 * k);
            rv = 32'hC3D4_E5F6 ^ (32'h1111_1111 * k);
            m  = mem[a[5:2]];
            e  = exp_merge(op, a[1:0], rv, m);
            run_op(op, a, 5'(k + 3), rv, 1'b0, 5'd0, 32'd0, 1'b0);
            chk(got_data === e, tag, got_data, e);
            chk(got_ldv === 1'b1 && got_idx === 5'(k + 3), "R8 load result tag",
                {26'd0, got_ldv, got_idx}, {26'd0, 1'b1, 5'(k + 3)});
            chk(last_rd_addr === {a[31:2], 2'b00}, "R2 aligned read", last_rd_addr, {a[31:2], 2'b00});
            chk(rd_cnt == 1 && wr_cnt == 0, "R9 load accesses", 32'(rd_cnt * 16 + wr_cnt), 32'd16);
        end
    endtask

    task automatic t_store(input logic [1:0] op, input string tag);
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a, rv, m, e;
            a  = 32'h0000_0020 + 32'(k) + 32'(4 * k);
            rv = 32'h2468_ACE0 + 32'(k);
            m  = mem[a[5:2]];
            e  = exp_merge(op, a[1:0], rv, m);
            run_op(op, a, 5'd7, rv, 1'b1, 5'd7, 32'hDEAD_0000, 1'b0);
            chk(last_wr_data === e, tag, last_wr_data, e);
            chk(last_wr_addr === {a[31:2], 2'b00}, "R2 aligned write", last_wr_addr, {a[31:2], 2'b00});
            chk(rd_cnt == 1 && wr_cnt == 1 && !order_bad, "R9 store read then write",
                32'(rd_cnt * 16 + wr_cnt), 32'd17);
            chk(got_ldv === 1'b0, "R8 store no load result", {31'd0, got_ldv}, 32'd0);
        end
    endtask

    task automatic t_forward();
        logic [31:0] m, e;
        m = mem[5];
        e = exp_merge(2'b00, 2'b10, 32'hAABB_CCDD, m);
        run_op(2'b00, 32'h16, 5'd12, 32'h1122_3344, 1'b1, 5'd12, 32'hAABB_CCDD, 1'b0);
        chk(got_data === e, "R7 forward on tag match", got_data, e);
        e = exp_merge(2'b01, 2'b01, 32'h1122_3344, m);
        run_op(2'b01, 32'h15, 5'd12, 32'h1122_3344, 1'b1, 5'd13, 32'hAABB_CCDD, 1'b0);
        chk(got_data === e, "R7 no forward on tag mismatch", got_data, e);
        run_op(2'b01, 32'h15, 5'd12, 32'h1122_3344, 1'b0, 5'd12, 32'hAABB_CCDD, 1'b0);
        chk(got_data === e, "R7 no forward when pending invalid", got_data, e);
    endtask

    task automatic t_stall();
        logic [31:0] m, e;
        lat = 3;
        m = mem[2];
        e = exp_merge(2'b11, 2'b01, 32'h5A6B_7C8D, m);
        run_op(2'b11, 32'h09, 5'd4, 32'h5A6B_7C8D, 1'b0, 5'd0, 32'd0, 1'b0);
        chk(last_wr_data === e, "R11 slow memory store data", last_wr_data, e);
        chk(rd_cnt == 1 && wr_cnt == 1 && !order_bad, "R11 slow memory access count",
            32'(rd_cnt * 16 + wr_cnt), 32'd17);
        lat = 0;
    endtask

    task automatic t_busy_ignore();
        logic [31:0] m, e, other;
        lat = 2;
        m = mem[1];
        other = mem[13];
        e = exp_merge(2'b10, 2'b11, 32'h0F1E_2D3C, m);
        run_op(2'b10, 32'h07, 5'd2, 32'h0F1E_2D3C, 1'b0, 5'd0, 32'd0, 1'b1);
        repeat (4) @(negedge clk);
        chk(rd_cnt == 1 && wr_cnt == 1, "R10 no extra access while busy",
            32'(rd_cnt * 16 + wr_cnt), 32'd17);
        chk(last_wr_addr === 32'h4 && last_wr_data === e, "R10 first op unaffected", last_wr_data, e);
        chk(mem[13] === other, "R10 ignored request wrote nothing", mem[13], other);
        chk(busy === 1'b0, "R10 idle after ignored request", {31'd0, busy}, 32'd0);
        lat = 0;
    endtask

    initial begin
        fill_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load(2'b00, "R3 load-right merge");
        t_load(2'b01, "R4 load-left merge");
        t_store(2'b10, "R5 store-right merge");
        t_store(2'b11, "R6 store-left merge");
        t_forward();
        t_stall();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule